// File: doc/BRIEF.md
# Sixteen-bit grouped lookahead adder

This block adds two 16-bit unsigned operands and a carry input in a single combinational path. The word is cut into four 4-bit slices. Each slice has four bit cells and a lookahead network. Each bit cell produces a sum bit and a per-bit generate and propagate. The lookahead network forms the carries into bits 1 to 3 of the slice directly from those per-bit terms and the slice carry-in. It also reduces the four bits to one slice generate and one slice propagate.

The carry leaving each slice comes from a small carry cell: generate OR (propagate AND carry-in). This is the same two-gate shape used for the carry into bit 1. That carry becomes the carry-in of the next slice, so carries ripple across the four slices and not through a second lookahead level. The slice generate and propagate flags are also brought out to the ports, so a wider lookahead stage could use them later.

There is no clock, no reset and no state. The state-machine conventions of the code base reduce here to the same naming and layout. The block has one "state": the settled value of its outputs for the present inputs. It has one transition: any input change.

Top module: `cla16_adder`

## Requirements
- R1: `{carry_out, sum_out}` equals `op_a + op_b + carry_in` as a 17-bit unsigned value, for every operand and carry combination.
- R2: `slice_gen[k]` is 1 exactly when the two 4-bit operand slices at bits 4k+3..4k, added without any carry, exceed 15.
- R3: `slice_prop[k]` is 1 exactly when those two 4-bit operand slices, added without any carry, equal 15.
- R4: `slice_gen[k]` and `slice_prop[k]` are never both 1.
- R5: The carry into slice k+1 equals the arithmetic carry out of bit 4k+3 of the full sum. The carry out of the top slice is `carry_out`.
- R6: Adding 1 to 0xFFFF, or 0xFFFF plus 0 with `carry_in` = 1, gives a sum of 0 with `carry_out` = 1.
- R7: Adding 1 to a word whose only 0 is at bit n sets bit n, clears all bits below n, keeps all bits above n at 1, and gives `carry_out` = 0.
- R8: Swapping `op_a` and `op_b` changes none of the outputs.
- R9: When every slice propagates (`op_a ^ op_b` = 0xFFFF), `carry_in` travels through all four slices: the result is sum 0 with carry_out 1 when `carry_in` = 1, and sum 0xFFFF with carry_out 0 when `carry_in` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |
| slice_gen | output | 4 | Generate flag for each 4-bit slice, bit k for bits 4k+3..4k |
| slice_prop | output | 4 | Propagate flag for each 4-bit slice, bit k for bits 4k+3..4k |

## Verification
The hardest case to reach from the ports is a carry that must cross a slice boundary through the ripple cell. A carry generated or propagated at one position has to travel through several slices, and it must stop exactly where a slice stops propagating. Random operands rarely make long all-propagate runs. The stimulus therefore builds them directly. It adds zero, every single-one word and every adjacent-two-ones word to all 65536 values of the other operand, alternating the operand order and the carry-in. Directed cases cover all-ones plus one, each lone-zero word plus one, and a fully propagating word with both carry-in values.

// File: rtl/cla_pkg.sv
`timescale 1ns/10ps
package cla_pkg;
    parameter int unsigned ADD_WIDTH  = 16;
    parameter int unsigned SLICE_BITS = 4;
    localparam int unsigned SLICE_COUNT = ADD_WIDTH / SLICE_BITS;

    // Per-bit carry terms produced by one bit cell
    typedef struct packed {
        logic gen;
        logic prop;
    } carry_term_t;
endpackage

// File: rtl/cla_carry_cell.sv
`timescale 1ns/10ps
// Two-gate carry former: gen OR (prop AND carry-in)
module cla_carry_cell (
    input  logic gen_in,
    input  logic prop_in,
    input  logic cin,
    output logic cout
);
    assign cout = gen_in | (prop_in & cin);
endmodule

// File: rtl/cla_bit_cell.sv
`timescale 1ns/10ps
// Partial full adder: sum plus per-bit generate/propagate, carry supplied externally
module cla_bit_cell
    import cla_pkg::*;
(
    input  logic        a_bit,
    input  logic        b_bit,
    input  logic        c_bit,
    output logic        s_bit,
    output carry_term_t term
);
    assign term.gen  = a_bit & b_bit;
    assign term.prop = a_bit ^ b_bit;
    assign s_bit     = term.prop ^ c_bit;
endmodule

// File: rtl/cla_lookahead.sv
`timescale 1ns/10ps
// Lookahead network for one slice: flat carries into bits 1..N-1, slice gen/prop
module cla_lookahead #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] gen_v,
    input  logic [N-1:0] prop_v,
    input  logic         cin,
    output logic [N-1:0] bit_carry,
    output logic         slice_g,
    output logic         slice_p
);
    always_comb begin
        logic acc;
        logic term;
        bit_carry    = '0;
        bit_carry[0] = cin;
        for (int i = 1; i < N; i++) begin
            acc = cin;
            for (int j = 0; j < i; j++) acc = acc & prop_v[j];
            for (int j = 0; j < i; j++) begin
                term = gen_v[j];
                for (int m = j + 1; m < i; m++) term = term & prop_v[m];
                acc = acc | term;
            end
            bit_carry[i] = acc;
        end
    end

    always_comb begin
        logic term;
        slice_g = 1'b0;
        slice_p = 1'b1;
        for (int j = 0; j < N; j++) begin
            term = gen_v[j];
            for (int m = j + 1; m < N; m++) term = term & prop_v[m];
            slice_g = slice_g | term;
            slice_p = slice_p & prop_v[j];
        end
    end
endmodule

// File: rtl/cla_slice.sv
`timescale 1ns/10ps
// One lookahead slice: bit cells, lookahead network, carry-out cell
module cla_slice
    import cla_pkg::*;
#(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] a_s,
    input  logic [N-1:0] b_s,
    input  logic         cin,
    output logic [N-1:0] sum_s,
    output logic         slice_g,
    output logic         slice_p,
    output logic         cout
);
    carry_term_t [N-1:0] terms;
    logic [N-1:0] gen_v;
    logic [N-1:0] prop_v;
    logic [N-1:0] bit_carry;

    for (genvar i = 0; i < N; i++) begin : g_bit
        cla_bit_cell u_cell (
            .a_bit (a_s[i]),
            .b_bit (b_s[i]),
            .c_bit (bit_carry[i]),
            .s_bit (sum_s[i]),
            .term  (terms[i])
        );
        assign gen_v[i]  = terms[i].gen;
        assign prop_v[i] = terms[i].prop;
    end

    cla_lookahead #(.N(N)) u_look (
        .gen_v     (gen_v),
        .prop_v    (prop_v),
        .cin       (cin),
        .bit_carry (bit_carry),
        .slice_g   (slice_g),
        .slice_p   (slice_p)
    );

    cla_carry_cell u_out (
        .gen_in  (slice_g),
        .prop_in (slice_p),
        .cin     (cin),
        .cout    (cout)
    );
endmodule

// File: rtl/cla16_adder.sv
`timescale 1ns/10ps
module cla16_adder
    import cla_pkg::*;
(
    input  logic [ADD_WIDTH-1:0]   op_a,
    input  logic [ADD_WIDTH-1:0]   op_b,
    input  logic                   carry_in,
    output logic [ADD_WIDTH-1:0]   sum_out,
    output logic                   carry_out,
    output logic [SLICE_COUNT-1:0] slice_gen,
    output logic [SLICE_COUNT-1:0] slice_prop
);
    // slice_carry[k] enters slice k; slice_carry[SLICE_COUNT] leaves the word
    logic [SLICE_COUNT:0] slice_carry;

    assign slice_carry[0] = carry_in;

    for (genvar k = 0; k < SLICE_COUNT; k++) begin : g_slice
        cla_slice #(.N(SLICE_BITS)) u_slice (
            .a_s     (op_a[k*SLICE_BITS +: SLICE_BITS]),
            .b_s     (op_b[k*SLICE_BITS +: SLICE_BITS]),
            .cin     (slice_carry[k]),
            .sum_s   (sum_out[k*SLICE_BITS +: SLICE_BITS]),
            .slice_g (slice_gen[k]),
            .slice_p (slice_prop[k]),
            .cout    (slice_carry[k+1])
        );
    end

    assign carry_out = slice_carry[SLICE_COUNT];
endmodule

// File: rtl/cla16_adder_checker.sv
`timescale 1ns/10ps
module cla16_adder_checker
    import cla_pkg::*;
(
    input logic [ADD_WIDTH-1:0]   op_a,
    input logic [ADD_WIDTH-1:0]   op_b,
    input logic                   carry_in,
    input logic [ADD_WIDTH-1:0]   sum_out,
    input logic                   carry_out,
    input logic [SLICE_COUNT-1:0] slice_gen,
    input logic [SLICE_COUNT-1:0] slice_prop,
    input logic [SLICE_COUNT:0]   slice_carry
);
    always_comb begin
        if (!$isunknown({op_a, op_b, carry_in, sum_out, carry_out})) begin
            assert_word_sum_R1: assert ({carry_out, sum_out} ==
                ({1'b0, op_a} + {1'b0, op_b} + {{ADD_WIDTH{1'b0}}, carry_in}))
                else $error("R1 sum mismatch");
        end
    end

    for (genvar k = 0; k < SLICE_COUNT; k++) begin : g_chk
        localparam int unsigned LO = k * SLICE_BITS;
        localparam int unsigned TOP = LO + SLICE_BITS;
        logic [SLICE_BITS:0] raw;
        logic [TOP:0]        low_sum;
        assign raw = {1'b0, op_a[LO +: SLICE_BITS]} + {1'b0, op_b[LO +: SLICE_BITS]};
        assign low_sum = {1'b0, op_a[TOP-1:0]} + {1'b0, op_b[TOP-1:0]}
                       + {{TOP{1'b0}}, carry_in};

        always_comb begin
            if (!$isunknown({op_a, op_b, carry_in, slice_gen, slice_prop, slice_carry})) begin
                assert_slice_gen_R2: assert (slice_gen[k] == (raw > 15))
                    else $error("R2 slice generate mismatch");
                assert_slice_prop_R3: assert (slice_prop[k] == (raw == 15))
                    else $error("R3 slice propagate mismatch");
                assert_gen_prop_excl_R4: assert (!(slice_gen[k] && slice_prop[k]))
                    else $error("R4 generate and propagate both set");
                assert_slice_ripple_R5: assert (slice_carry[k+1] == low_sum[TOP])
                    else $error("R5 slice carry mismatch");
            end
        end
    end
endmodule

bind cla16_adder cla16_adder_checker u_cla16_adder_checker (
    .op_a        (op_a),
    .op_b        (op_b),
    .carry_in    (carry_in),
    .sum_out     (sum_out),
    .carry_out   (carry_out),
    .slice_gen   (slice_gen),
    .slice_prop  (slice_prop),
    .slice_carry (slice_carry)
);

// File: tb/cla16_adder_bench.sv
`timescale 1ns/10ps
module cla16_adder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        carry_in = 1'b0;
    logic [15:0] sum_out;
    logic        carry_out;
    logic [3:0]  slice_gen;
    logic [3:0]  slice_prop;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cla16_adder u_cla16_adder (
        .op_a       (op_a),
        .op_b       (op_b),
        .carry_in   (carry_in),
        .sum_out    (sum_out),
        .carry_out  (carry_out),
        .slice_gen  (slice_gen),
        .slice_prop (slice_prop)
    );

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        for (int n = 0; n < 190000; n++) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    // Drive, settle, then check the word result and slice flags
    task automatic apply(input logic [15:0] a, input logic [15:0] b,
                         input logic ci, input string tag);
        logic [16:0] exp_w;
        logic [3:0]  exp_g;
        logic [3:0]  exp_p;
        op_a = a;
        op_b = b;
        carry_in = ci;
        #0.25;
        exp_w = {1'b0, a} + {1'b0, b} + {16'd0, ci};
        for (int k = 0; k < 4; k++) begin
            exp_g[k] = ((a >> (4*k)) & 16'hF) + ((b >> (4*k)) & 16'hF) > 15;
            exp_p[k] = ((a >> (4*k)) & 16'hF) + ((b >> (4*k)) & 16'hF) == 15;
        end
        checks++;
        if ({carry_out, sum_out} !== exp_w) begin
            failures++;
            $display("FAIL %s R1 a=%h b=%h ci=%b actual=%h expected=%h",
                     tag, a, b, ci, {carry_out, sum_out}, exp_w);
        end
        checks++;
        if (slice_gen !== exp_g || slice_prop !== exp_p) begin
            failures++;
            $display("FAIL R2 R3 R4 a=%h b=%h actual g=%b p=%b expected g=%b p=%b",
                     a, b, slice_gen, slice_prop, exp_g, exp_p);
        end
    endtask

    // Both operand orders, and the swap must give identical outputs (R8)
    task automatic apply_both(input logic [15:0] a, input logic [15:0] b,
                              input logic ci, input string tag);
        logic [24:0] first;
        apply(a, b, ci, tag);
        first = {carry_out, sum_out, slice_gen, slice_prop};
        apply(b, a, ci, tag);
        checks++;
        if ({carry_out, sum_out, slice_gen, slice_prop} !== first) begin
            failures++;
            $display("FAIL R8 swap a=%h b=%h actual=%h expected=%h",
                     a, b, {carry_out, sum_out, slice_gen, slice_prop}, first);
        end
    endtask

    initial begin
        logic [15:0] pat;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Quiet state: zero operands give zero outputs
        apply(16'h0000, 16'h0000, 1'b0, "R1 reset-state");

        // R6: all-ones plus one, both forms
        apply_both(16'hFFFF, 16'h0001, 1'b0, "R6");
        apply_both(16'hFFFF, 16'h0000, 1'b1, "R6");
        checks++;
        if (sum_out !== 16'h0000 || carry_out !== 1'b1) begin
            failures++;
            $display("FAIL R6 actual=%b_%h expected=1_0000", carry_out, sum_out);
        end

        // R7: lone-zero words plus one
        for (int n = 0; n < 16; n++) begin
            pat = ~(16'h0001 << n);
            apply_both(pat, 16'h0001, 1'b0, "R7");
            checks++;
            if (carry_out !== 1'b0 || sum_out !== (16'hFFFF << n)) begin
                failures++;
                $display("FAIL R7 bit=%0d actual=%b_%h expected=0_%h",
                         n, carry_out, sum_out, 16'hFFFF << n);
            end
        end

        // R9: every slice propagates, carry-in crosses all four slices
        apply_both(16'hA5A5, 16'h5A5A, 1'b1, "R9");
        checks++;
        if (sum_out !== 16'h0000 || carry_out !== 1'b1 || slice_prop !== 4'hF) begin
            failures++;
            $display("FAIL R9 cin=1 actual=%b_%h p=%b expected=1_0000 p=1111",
                     carry_out, sum_out, slice_prop);
        end
        apply_both(16'h0F0F, 16'hF0F0, 1'b0, "R9");
        checks++;
        if (sum_out !== 16'hFFFF || carry_out !== 1'b0) begin
            failures++;
            $display("FAIL R9 cin=0 actual=%b_%h expected=0_ffff", carry_out, sum_out);
        end

        // R5 sweep: zero, lone ones, adjacent pairs against every other operand
        for (int idx = 0; idx < 32; idx++) begin
            if (idx == 0)       pat = 16'h0000;
            else if (idx <= 16) pat = 16'h0001 << (idx - 1);
            else                pat = 16'h0003 << (idx - 17);
            for (int v = 0; v < 65536; v++) begin
                if (v[0]) apply(16'(v), pat, v[1], "R5 sweep");
                else      apply(pat, 16'(v), v[1], "R5 sweep");
            end
        end

        finished = 1'b1;
        report();
    end
endmodule